// File: doc/BRIEF.md
# Arithmetic Instruction Carry and Writeback Control

This block sits beside the datapath of a microcoded processor. During the microinstruction that retires a register-to-register arithmetic instruction, it works out the carry bit that feeds the shifter. It also decides whether the shifted result goes back to the destination accumulator, and which accumulator that is. The block holds the architectural carry flip-flop. A one-bit rotate-through-carry shifter is built in, so the shifted word and the next carry leave the block together.

The carry is found in two steps. First, a two-bit carry-control field of the instruction picks a base value: keep, zero, one or complement. Second, that base is flipped by the ALU carry-out when the instruction's ALU operation belongs to the carry-producing class. The shift field then rotates the 17-bit quantity {carry, word}, or swaps the bytes of the word. The carry that results is what the flip-flop stores at the clock edge.

There is no stall path, so there is no back-pressure. All outputs are combinational from the inputs and the carry flip-flop, and they are valid in the same cycle that `step_en` is high. The only state, the carry flip-flop, advances on an edge only when `step_en` is high. Instruction bit numbering is LSB = 0.

Top module: `arith_carry_ctl`

## Requirements
- R1: The base carry comes from ir[5:4]. 0 gives the current carry flip-flop, 1 gives 0, 2 gives 1, and 3 gives the inverted current carry.
- R2: When the operation code ir[10:8] is 1, 3, 4, 5 or 6, `carry_mod` is the base carry XOR `alu_cout`.
- R3: When the operation code ir[10:8] is 0, 2 or 7, `carry_mod` equals the base carry, whatever `alu_cout` is.
- R4: While `step_en` is 1, `wb_en` is the inverse of the no-load bit ir[3]. It ignores `ld_req`.
- R5: While `step_en` is 0, `wb_en` follows `ld_req`.
- R6: `wb_idx` equals 3 minus ir[12:11].
- R7: With shift code ir[7:6] = 1, the 17-bit value {carry_mod, alu_res} rotates left by one. `sh_carry` = alu_res[15] and `sh_data` = {alu_res[14:0], carry_mod}.
- R8: With shift code 2, the 17-bit value rotates right by one. `sh_carry` = alu_res[0] and `sh_data` = {carry_mod, alu_res[15:1]}.
- R9: With shift code 3, `sh_data` is alu_res with its bytes swapped. With shift code 0, `sh_data` equals alu_res. In both cases `sh_carry` equals `carry_mod`.
- R10: `carry_q` is 0 after reset. It loads `sh_carry` at a rising edge when `step_en` is 1, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | Marks the arithmetic writeback microinstruction |
| ir | input | 16 | Instruction register |
| ld_req | input | 1 | Register-load request from the microinstruction |
| alu_res | input | 16 | ALU result word |
| alu_cout | input | 1 | ALU carry-out |
| carry_q | output | 1 | Carry flip-flop |
| carry_mod | output | 1 | Computed carry into the shifter |
| sh_data | output | 16 | Shifter output word |
| sh_carry | output | 1 | Carry out of the shifter |
| wb_en | output | 1 | Destination register load enable |
| wb_idx | output | 2 | Destination register index |

## Verification
The carry path is swept over every pairing of carry-control code, operation code and ALU carry-out, with the flip-flop at both values. This separates the four base selections from each other and shows which operation classes respond to `alu_cout`. Edge words such as 8000, 0001, FFFF, 0000 and A5C3 go through each shift code, so the bits moved into and out of the carry can be told apart from those that stay in the word. Steps with `step_en` low, and steps with the no-load bit set while `ld_req` is high, show that the carry holds and that the load request is overridden.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [1:0] {CC_KEEP, CC_ZERO, CC_ONE, CC_FLIP} cc_e;
  typedef enum logic [1:0] {SH_NONE, SH_ROL, SH_ROR, SH_SWAP} sh_e;
  typedef enum logic [2:0] {
    OP_COM, OP_NEG, OP_MOV, OP_INC, OP_ADC, OP_SUB, OP_ADD, OP_AND
  } op_e;

  localparam int NL_BIT  = 3;
  localparam int CC_LSB  = 4;
  localparam int SH_LSB  = 6;
  localparam int OP_LSB  = 8;
  localparam int DST_LSB = 11;

  // Operations whose carry-out flips the base carry.
  function automatic logic op_flips(op_e op);
    return (op == OP_NEG) || (op == OP_INC) || (op == OP_ADC) ||
           (op == OP_SUB) || (op == OP_ADD);
  endfunction
endpackage

// File: rtl/acc_carry_sel.sv
module acc_carry_sel
  import acc_pkg::*;
(
  input  cc_e  cc,
  input  op_e  op,
  input  logic cur_c,
  input  logic alu_cout,
  output logic c_out
);
  logic base_c;

  always_comb begin
    case (cc)
      CC_KEEP: base_c = cur_c;
      CC_ZERO: base_c = 1'b0;
      CC_ONE:  base_c = 1'b1;
      default: base_c = ~cur_c;
    endcase
    c_out = base_c ^ (op_flips(op) & alu_cout);
  end
endmodule

// File: rtl/acc_rot_shift.sv
module acc_rot_shift
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  sh_e               mode,
  input  logic [DATA_W-1:0] d,
  input  logic              c_in,
  output logic [DATA_W-1:0] q,
  output logic              c_out
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] swapped;

  generate
    if (DATA_W % 2 == 0) begin : g_even
      assign swapped = {d[HALF-1:0], d[DATA_W-1:HALF]};
    end else begin : g_odd
      assign swapped = d;
    end
  endgenerate

  always_comb begin
    case (mode)
      SH_ROL: begin
        q     = {d[DATA_W-2:0], c_in};
        c_out = d[DATA_W-1];
      end
      SH_ROR: begin
        q     = {c_in, d[DATA_W-1:1]};
        c_out = d[0];
      end
      SH_SWAP: begin
        q     = swapped;
        c_out = c_in;
      end
      default: begin
        q     = d;
        c_out = c_in;
      end
    endcase
  end
endmodule

// File: rtl/acc_wb_ctl.sv
module acc_wb_ctl (
  input  logic       step,
  input  logic       no_load,
  input  logic       req,
  input  logic [1:0] dst,
  output logic       en,
  output logic [1:0] idx
);
  always_comb begin
    en  = step ? ~no_load : req;
    idx = 2'd3 - dst;
  end
endmodule

// File: rtl/arith_carry_ctl.sv
module arith_carry_ctl
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [IR_W-1:0]   ir,
  input  logic              ld_req,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  output logic              carry_q,
  output logic              carry_mod,
  output logic [DATA_W-1:0] sh_data,
  output logic              sh_carry,
  output logic              wb_en,
  output logic [1:0]        wb_idx
);
  localparam int MSB = DATA_W - 1;

  cc_e cc;
  sh_e sh;
  op_e op;
  logic ir_unused;

  assign cc = cc_e'(ir[CC_LSB +: 2]);
  assign sh = sh_e'(ir[SH_LSB +: 2]);
  assign op = op_e'(ir[OP_LSB +: 3]);
  assign ir_unused = ^{ir[IR_W-1:DST_LSB+2], ir[NL_BIT-1:0]};

  acc_carry_sel u_sel (
    .cc(cc), .op(op), .cur_c(carry_q), .alu_cout(alu_cout), .c_out(carry_mod)
  );

  acc_rot_shift #(.DATA_W(DATA_W)) u_sh (
    .mode(sh), .d(alu_res), .c_in(carry_mod), .q(sh_data), .c_out(sh_carry)
  );

  acc_wb_ctl u_wb (
    .step(step_en), .no_load(ir[NL_BIT]), .req(ld_req),
    .dst(ir[DST_LSB +: 2]), .en(wb_en), .idx(wb_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       carry_q <= 1'b0;
    else if (step_en) carry_q <= sh_carry;
  end

  // R10: carry holds without a step
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(carry_q));

  // R1: forced zero reaches the flip-flop when no rotate and no flip
  p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cc == CC_ZERO && !op_flips(op) && (sh == SH_NONE || sh == SH_SWAP))
    |=> !carry_q);

  // R3: forced one is kept regardless of alu_cout for pass-through ops
  p_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cc == CC_ONE && !op_flips(op) && (sh == SH_NONE || sh == SH_SWAP))
    |=> carry_q);

  // R7: rotate left stores the word msb
  p_rol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sh == SH_ROL) |=> carry_q == $past(alu_res[MSB]));

  // R8: rotate right stores the word lsb
  p_ror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sh == SH_ROR) |=> carry_q == $past(alu_res[0]));

  // R4: no-load bit wins over the load request
  p_noload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && ir[NL_BIT]) |-> !wb_en);

  // R6: index and field sum to three
  p_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (2'(wb_idx + ir[DST_LSB +: 2]) == 2'd3));
endmodule

// File: tb/sim_arith_carry_ctl.sv
`timescale 1ns/1ps
module sim_arith_carry_ctl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, step_en, ld_req, alu_cout;
  logic [15:0] ir, alu_res;
  logic carry_q, carry_mod, sh_carry, wb_en;
  logic [15:0] sh_data;
  logic [1:0] wb_idx;

  arith_carry_ctl u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ir(ir), .ld_req(ld_req),
    .alu_res(alu_res), .alu_cout(alu_cout), .carry_q(carry_q),
    .carry_mod(carry_mod), .sh_data(sh_data), .sh_carry(sh_carry),
    .wb_en(wb_en), .wb_idx(wb_idx)
  );

  typedef struct {
    logic [15:0] ir;
    logic        st;
    logic        cq;
    logic        cm;
    logic [15:0] q;
    logic        qc;
    logic        wb;
    logic [1:0]  idx;
  } exp_t;

  exp_t sbq[$];
  event ev;
  int checks = 0;
  int errors = 0;
  logic mc = 1'b0;
  bit done = 0;

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] iv, input logic st, input logic rq,
                       input logic [15:0] d, input logic ac);
    exp_t e;
    logic base, flip;
    @(negedge clk);
    ir = iv; step_en = st; ld_req = rq; alu_res = d; alu_cout = ac;
    #1;
    case (iv[5:4])
      2'd0: base = mc;
      2'd1: base = 1'b0;
      2'd2: base = 1'b1;
      default: base = ~mc;
    endcase
    flip = (iv[10:8] inside {3'd1, 3'd3, 3'd4, 3'd5, 3'd6});
    e.ir = iv; e.st = st; e.cq = mc;
    e.cm = base ^ (flip & ac);
    case (iv[7:6])
      2'd1: begin e.q = {d[14:0], e.cm}; e.qc = d[15]; end
      2'd2: begin e.q = {e.cm, d[15:1]}; e.qc = d[0]; end
      2'd3: begin e.q = {d[7:0], d[15:8]}; e.qc = e.cm; end
      default: begin e.q = d; e.qc = e.cm; end
    endcase
    e.wb  = st ? ~iv[3] : rq;
    e.idx = 2'd3 - iv[12:11];
    sbq.push_back(e);
    ->ev;
    if (st) mc = e.qc;
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(ev);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        cmp("R10 carry_q", {15'd0, carry_q}, {15'd0, e.cq});
        if (e.ir[10:8] inside {3'd1, 3'd3, 3'd4, 3'd5, 3'd6})
          cmp("R1 R2 carry_mod", {15'd0, carry_mod}, {15'd0, e.cm});
        else
          cmp("R1 R3 carry_mod", {15'd0, carry_mod}, {15'd0, e.cm});
        case (e.ir[7:6])
          2'd1: cmp("R7 sh_data/carry", {sh_data[14:0], sh_carry}, {e.q[14:0], e.qc});
          2'd2: cmp("R8 sh_data/carry", {sh_data[14:0], sh_carry}, {e.q[14:0], e.qc});
          default: cmp("R9 sh_data/carry", {sh_data[14:0], sh_carry}, {e.q[14:0], e.qc});
        endcase
        cmp("R7 R8 R9 sh_data msb", {15'd0, sh_data[15]}, {15'd0, e.q[15]});
        if (e.st) cmp("R4 wb_en", {15'd0, wb_en}, {15'd0, e.wb});
        else      cmp("R5 wb_en", {15'd0, wb_en}, {15'd0, e.wb});
        cmp("R6 wb_idx", {14'd0, wb_idx}, {14'd0, e.idx});
      end
    end
  end

  function automatic logic [15:0] mk(input logic [1:0] dst, input logic [2:0] op,
                                     input logic [1:0] sh, input logic [1:0] cc,
                                     input logic nl);
    return {3'b000, dst, op, sh, cc, nl, 3'b101};
  endfunction

  initial begin
    logic [15:0] pats [5];
    pats[0] = 16'h8000; pats[1] = 16'h0001; pats[2] = 16'hA5C3;
    pats[3] = 16'hFFFF; pats[4] = 16'h0000;
    rst_n = 1'b0; step_en = 1'b0; ld_req = 1'b0; ir = '0; alu_res = '0; alu_cout = 1'b0;
    repeat (3) @(posedge clk);
    #1 cmp("R10 reset carry_q", {15'd0, carry_q}, 16'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1 R2 R3: all control codes, op codes and carry-outs, no shift
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++)
        for (int o = 0; o < 8; o++)
          for (int a = 0; a < 2; a++)
            drive(mk(2'(o), 3'(o), 2'd0, 2'(c), 1'(a ^ r)), 1'b1, 1'b1, 16'h1234, 1'(a));

    // R7 R8 R9: each shift over edge words, both carry values
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 5; p++)
        for (int c = 1; c < 3; c++)
          drive(mk(2'(p), 3'd2, 2'(s), 2'(c), 1'b0), 1'b1, 1'b0, pats[p], 1'b0);

    // R10 R5: no step, carry must hold, load request passes through
    drive(mk(2'd0, 3'd2, 2'd0, 2'd2, 1'b0), 1'b1, 1'b0, 16'h0, 1'b0);
    for (int k = 0; k < 4; k++)
      drive(mk(2'(k), 3'(k * 2 + 1), 2'(k), 2'(k), 1'(k)), 1'b0, 1'(k), 16'h8001, 1'b1);

    // R4: no-load bit overrides load request
    drive(mk(2'd3, 3'd6, 2'd1, 2'd3, 1'b1), 1'b1, 1'b1, 16'h7FFE, 1'b1);
    drive(mk(2'd1, 3'd5, 2'd2, 2'd0, 1'b0), 1'b1, 1'b0, 16'h0003, 1'b1);
    drive(mk(2'd2, 3'd0, 2'd0, 2'd0, 1'b0), 1'b0, 1'b0, 16'h0, 1'b0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule